// File: doc/BRIEF.md
# Player Position, Collision and Score Tracker

This block keeps track of a single-cell player that lives in one fixed column of a small scrolling display game. The player sinks one row on every gravity tick and climbs one row on every gravity tick while the up button is held, using one saturating up/down counter. The button level picks the count direction. A start pulse places the player in the middle row, clears the score and the collision flag, and starts the run.

Every cycle of a run, the block compares the player's one-hot row vector with the wall cells currently in the player column. Any overlap is a collision. A collision freezes the player, drops the run flag and raises a sticky collision flag. When a scroll tick brings a column containing wall cells into the player column and the player does not touch any of them, the score counts up by one, stopping at a single-digit ceiling. While the run flag is low, position and score hold their values.

Top module: `player_track`

## Requirements
- R1: After synchronous reset, position is 4, the one-hot column is 8'h10, and the collision flag, run flag and score are all 0.
- R2: A start pulse sets position to 4, score to 0, collision flag to 0 and run flag to 1 on the next clock edge. Start has priority over all other inputs.
- R3: While running with no collision, a gravity tick with up low lowers position by 1, and a gravity tick with up high raises it by 1. Without a gravity tick, position holds.
- R4: Position saturates: a downward step at 0 stays 0 and an upward step at 7 stays 7.
- R5: The one-hot output has exactly bit `position` set, where bit 0 is the bottom row.
- R6: While running, if any wall bit is set at the player's row, the next edge sets the collision flag, clears the run flag and leaves position unchanged.
- R7: While the run flag is low (and start is low), position and score hold regardless of ticks, button or wall bits.
- R8: While running, a scroll tick with a nonzero wall column that does not overlap the player increments the score by 1. The wall column input shows the column being brought in during the tick cycle.
- R9: The score does not change on a scroll tick with an all-zero wall column, nor when a scroll tick coincides with a collision, nor without a scroll tick.
- R10: The score saturates at 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse |
| up_i | input | 1 | Debounced up-button level |
| grav_tick_i | input | 1 | Movement tick, one cycle wide |
| scroll_tick_i | input | 1 | Wall scroll tick, one cycle wide |
| wall_col_i | input | 8 | Wall cells in the player column, bit 0 bottom |
| pos_o | output | 3 | Player row |
| pos_onehot_o | output | 8 | One-hot player row |
| hit_o | output | 1 | Sticky collision flag |
| run_o | output | 1 | Game running |
| score_o | output | 4 | Walls passed |

## Verification
The bench drives the player to both edges of the column and keeps ticking there. A counter that wraps instead of saturating would show 0 after 7 or 7 after 0. It scrolls in empty columns and non-overlapping columns, and a design that scores on any scroll tick would count the empty ones. It lines up a scroll tick with a collision, where a wrong design would both score and stop. It also applies ticks after a crash, where a design that is not gated by the run flag would keep moving or scoring. Finally, it pushes the score past the single-digit ceiling, which exposes a missing saturation as a 10 or a wrap.

// File: rtl/player_pkg.sv
package player_pkg;

    typedef enum logic [1:0] {
        MV_HOLD = 2'd0,
        MV_DOWN = 2'd1,
        MV_UP   = 2'd2
    } move_e;

    typedef struct packed {
        logic start;
        logic up;
        logic grav;
        logic scroll;
    } ctrl_t;

    function automatic move_e pick_move(input logic run, input logic hit,
                                        input logic grav, input logic up);
        if (!run || hit || !grav) return MV_HOLD;
        return up ? MV_UP : MV_DOWN;
    endfunction

endpackage

// File: rtl/player_pos.sv
module player_pos
    import player_pkg::*;
#(
    parameter int ROWS      = 8,
    parameter int START_ROW = 4,
    localparam int POS_W    = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  move_e            move,
    output logic [POS_W-1:0] pos,
    output logic [ROWS-1:0]  onehot
);
    localparam logic [POS_W-1:0] TOP  = POS_W'(ROWS - 1);
    localparam logic [POS_W-1:0] HOME = POS_W'(START_ROW);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            pos <= HOME;
        end else begin
            case (move)
                MV_UP:   if (pos != TOP)         pos <= pos + 1'b1;
                MV_DOWN: if (pos != '0)          pos <= pos - 1'b1;
                default: pos <= pos;
            endcase
        end
    end

    for (genvar i = 0; i < ROWS; i++) begin : g_dec
        assign onehot[i] = (pos == POS_W'(i));
    end
endmodule

// File: rtl/player_hit.sv
module player_hit #(
    parameter int ROWS = 8
) (
    input  logic [ROWS-1:0] onehot,
    input  logic [ROWS-1:0] wall,
    output logic            overlap,
    output logic            any_wall
);
    assign overlap  = |(onehot & wall);
    assign any_wall = |wall;
endmodule

// File: rtl/player_score.sv
module player_score #(
    parameter int SCORE_W   = 4,
    parameter int SCORE_MAX = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               bump,
    output logic [SCORE_W-1:0] score
);
    localparam logic [SCORE_W-1:0] CAP = SCORE_W'(SCORE_MAX);

    always_ff @(posedge clk) begin
        if (rst || clear)             score <= '0;
        else if (bump && score != CAP) score <= score + 1'b1;
    end
endmodule

// File: rtl/player_track.sv
module player_track
    import player_pkg::*;
#(
    parameter int ROWS      = 8,
    parameter int START_ROW = 4,
    parameter int SCORE_W   = 4,
    parameter int SCORE_MAX = 9,
    localparam int POS_W    = $clog2(ROWS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               up_i,
    input  logic               grav_tick_i,
    input  logic               scroll_tick_i,
    input  logic [ROWS-1:0]    wall_col_i,
    output logic [POS_W-1:0]   pos_o,
    output logic [ROWS-1:0]    pos_onehot_o,
    output logic               hit_o,
    output logic               run_o,
    output logic [SCORE_W-1:0] score_o
);
    ctrl_t ctrl;
    logic  overlap, any_wall, crash, bump;
    move_e move;

    assign ctrl  = '{start: start_i, up: up_i, grav: grav_tick_i, scroll: scroll_tick_i};
    assign crash = run_o && overlap;
    assign move  = pick_move(run_o, overlap, ctrl.grav, ctrl.up);
    assign bump  = run_o && ctrl.scroll && any_wall && !overlap;

    player_pos #(.ROWS(ROWS), .START_ROW(START_ROW)) u_pos (
        .clk(clk), .rst(rst), .load(ctrl.start), .move(move),
        .pos(pos_o), .onehot(pos_onehot_o)
    );

    player_hit #(.ROWS(ROWS)) u_hit (
        .onehot(pos_onehot_o), .wall(wall_col_i),
        .overlap(overlap), .any_wall(any_wall)
    );

    player_score #(.SCORE_W(SCORE_W), .SCORE_MAX(SCORE_MAX)) u_score (
        .clk(clk), .rst(rst), .clear(ctrl.start), .bump(bump), .score(score_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            run_o <= 1'b0;
            hit_o <= 1'b0;
        end else if (ctrl.start) begin
            run_o <= 1'b1;
            hit_o <= 1'b0;
        end else if (crash) begin
            run_o <= 1'b0;
            hit_o <= 1'b1;
        end
    end
endmodule

// File: rtl/player_track_chk.sv
module player_track_chk #(
    parameter int ROWS      = 8,
    parameter int START_ROW = 4,
    parameter int SCORE_W   = 4,
    parameter int SCORE_MAX = 9,
    localparam int POS_W    = $clog2(ROWS)
) (
    input logic               clk,
    input logic               rst,
    input logic               start_i,
    input logic               grav_tick_i,
    input logic               scroll_tick_i,
    input logic [ROWS-1:0]    wall_col_i,
    input logic [POS_W-1:0]   pos_o,
    input logic [ROWS-1:0]    pos_onehot_o,
    input logic               hit_o,
    input logic               run_o,
    input logic [SCORE_W-1:0] score_o
);
    a_r2_start_load: assert property (@(posedge clk) disable iff (rst)
        start_i |=> run_o && !hit_o && score_o == '0 && pos_o == POS_W'(START_ROW));

    a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
        !start_i && !grav_tick_i |=> $stable(pos_o));

    a_r5_onehot_match: assert property (@(posedge clk) disable iff (rst)
        $countones(pos_onehot_o) == 1 && pos_onehot_o[pos_o]);

    a_r6_crash_stops: assert property (@(posedge clk) disable iff (rst)
        run_o && !start_i && (|(pos_onehot_o & wall_col_i)) |=> hit_o && !run_o && $stable(pos_o));

    a_r7_frozen: assert property (@(posedge clk) disable iff (rst)
        !run_o && !start_i |=> $stable(pos_o) && $stable(score_o));

    a_r9_no_scroll_hold: assert property (@(posedge clk) disable iff (rst)
        !start_i && !scroll_tick_i |=> $stable(score_o));

    a_r10_score_cap: assert property (@(posedge clk) disable iff (rst)
        score_o <= SCORE_W'(SCORE_MAX));
endmodule

bind player_track player_track_chk #(
    .ROWS(ROWS), .START_ROW(START_ROW), .SCORE_W(SCORE_W), .SCORE_MAX(SCORE_MAX)
) u_chk (
    .clk(clk), .rst(rst), .start_i(start_i), .grav_tick_i(grav_tick_i),
    .scroll_tick_i(scroll_tick_i), .wall_col_i(wall_col_i), .pos_o(pos_o),
    .pos_onehot_o(pos_onehot_o), .hit_o(hit_o), .run_o(run_o), .score_o(score_o)
);

// File: tb/player_track_test.sv
module player_track_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0, up_i = 1'b0, grav_tick_i = 1'b0, scroll_tick_i = 1'b0;
    logic [7:0] wall_col_i = 8'h00;
    logic [2:0] pos_o;
    logic [7:0] pos_onehot_o;
    logic       hit_o, run_o;
    logic [3:0] score_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    player_track uut (
        .clk(clk), .rst(rst), .start_i(start_i), .up_i(up_i),
        .grav_tick_i(grav_tick_i), .scroll_tick_i(scroll_tick_i),
        .wall_col_i(wall_col_i), .pos_o(pos_o), .pos_onehot_o(pos_onehot_o),
        .hit_o(hit_o), .run_o(run_o), .score_o(score_o)
    );

    typedef struct packed {
        logic       st;
        logic       up;
        logic       gr;
        logic       sc;
        logic [7:0] wall;
        logic [2:0] e_pos;
        logic       e_run;
        logic       e_hit;
        logic [3:0] e_score;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,1'b0,1'b0,8'h00,3'd4,1'b1,1'b0,4'd0}, // R2 start
        '{1'b0,1'b0,1'b1,1'b0,8'h00,3'd3,1'b1,1'b0,4'd0}, // R3 fall
        '{1'b0,1'b1,1'b1,1'b0,8'h00,3'd4,1'b1,1'b0,4'd0}, // R3 rise
        '{1'b0,1'b1,1'b0,1'b0,8'h00,3'd4,1'b1,1'b0,4'd0}, // R3 no tick
        '{1'b0,1'b1,1'b1,1'b0,8'h00,3'd5,1'b1,1'b0,4'd0},
        '{1'b0,1'b1,1'b1,1'b0,8'h00,3'd6,1'b1,1'b0,4'd0},
        '{1'b0,1'b1,1'b1,1'b0,8'h00,3'd7,1'b1,1'b0,4'd0},
        '{1'b0,1'b1,1'b1,1'b0,8'h00,3'd7,1'b1,1'b0,4'd0}, // R4 top
        '{1'b0,1'b0,1'b0,1'b1,8'h0F,3'd7,1'b1,1'b0,4'd1}, // R8 pass
        '{1'b0,1'b0,1'b0,1'b1,8'h00,3'd7,1'b1,1'b0,4'd1}, // R9 empty
        '{1'b0,1'b0,1'b0,1'b0,8'h0F,3'd7,1'b1,1'b0,4'd1}, // R9 no scroll
        '{1'b0,1'b0,1'b1,1'b0,8'h00,3'd6,1'b1,1'b0,4'd1},
        '{1'b0,1'b0,1'b1,1'b0,8'h00,3'd5,1'b1,1'b0,4'd1},
        '{1'b0,1'b0,1'b1,1'b0,8'h00,3'd4,1'b1,1'b0,4'd1},
        '{1'b0,1'b0,1'b1,1'b0,8'h00,3'd3,1'b1,1'b0,4'd1},
        '{1'b0,1'b0,1'b1,1'b0,8'h00,3'd2,1'b1,1'b0,4'd1},
        '{1'b0,1'b0,1'b1,1'b0,8'h00,3'd1,1'b1,1'b0,4'd1},
        '{1'b0,1'b0,1'b1,1'b0,8'h00,3'd0,1'b1,1'b0,4'd1},
        '{1'b0,1'b0,1'b1,1'b0,8'h00,3'd0,1'b1,1'b0,4'd1}, // R4 bottom
        '{1'b0,1'b0,1'b0,1'b1,8'hFE,3'd0,1'b1,1'b0,4'd2}, // R8 pass
        '{1'b0,1'b1,1'b1,1'b0,8'h01,3'd0,1'b0,1'b1,4'd2}, // R6 crash, no move
        '{1'b0,1'b1,1'b1,1'b1,8'h0E,3'd0,1'b0,1'b1,4'd2}, // R7 frozen
        '{1'b0,1'b0,1'b1,1'b1,8'h00,3'd0,1'b0,1'b1,4'd2}, // R7 frozen
        '{1'b1,1'b0,1'b0,1'b0,8'h00,3'd4,1'b1,1'b0,4'd0}, // R2 restart
        '{1'b0,1'b0,1'b0,1'b1,8'h10,3'd4,1'b0,1'b1,4'd0}  // R9 scroll with crash
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic st, input logic up, input logic gr,
                         input logic sc, input logic [7:0] wall);
        @(negedge clk);
        start_i = st; up_i = up; grav_tick_i = gr; scroll_tick_i = sc; wall_col_i = wall;
        @(posedge clk);
        #1;
    endtask

    task automatic state_check(input string tag, input logic [2:0] p, input logic r,
                               input logic h, input logic [3:0] s);
        check({tag, " pos"}, int'(pos_o), int'(p));
        check("R5 onehot", int'(pos_onehot_o), int'(8'h01 << p));
        check({tag, " run"}, int'(run_o), int'(r));
        check({tag, " hit"}, int'(hit_o), int'(h));
        check({tag, " score"}, int'(score_o), int'(s));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        state_check("R1 reset", 3'd4, 1'b0, 1'b0, 4'd0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].st, VEC[i].up, VEC[i].gr, VEC[i].sc, VEC[i].wall);
            state_check($sformatf("vec%0d", i), VEC[i].e_pos, VEC[i].e_run,
                        VEC[i].e_hit, VEC[i].e_score);
        end

        // R10: score saturation, player at row 4, walls at row 0 only
        drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        for (int k = 0; k < 11; k++) drive(1'b0, 1'b0, 1'b0, 1'b1, 8'h01);
        state_check("R10 cap", 3'd4, 1'b1, 1'b0, 4'd9);

        // R7: ticks while idle after reset do nothing
        drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        @(negedge clk); rst = 1'b0;
        drive(1'b0, 1'b1, 1'b1, 1'b1, 8'h03);
        state_check("R7 idle", 3'd4, 1'b0, 1'b0, 4'd0);

        drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule